// File: doc/BRIEF.md
# Watchdog Start/Stop Sequence Controller

This block decides whether a 32-bit watchdog counter is allowed to run. Software controls it through a small register window. The run flag moves only when software writes a matched pair of key words to one control register. The first word arms the change and the second word commits it. One pair halts the watchdog and a different pair resumes it. Any other word seen in the middle of a pair cancels the armed state.

The same window also holds several target registers that belong to the slower watchdog clock domain. A write to one of them is posted. The value is held on the bus side and handed across the clock boundary with a toggle handshake, using a two-flop synchronizer in each direction. A per-target pending bit is readable from the status register. It reads 1 from the write until the acknowledge returns, and it clears without any software action. While a target's bit is set, a further write to that target is dropped, so the transfer in flight is never corrupted. A small stub in the watchdog domain counts while the enable is high, so that the enable has a visible consumer.

Top module: `wdt_keyctl`

## Requirements
- R1: After reset, run_en is 1, pend is all zero, wd_count and every wd_regs slice are 0, and a read of the key register (address 0) returns 0x00000000.
- R2: Writing bits [15:0] = 0xAAAA and then bits [15:0] = 0x5555 to address 0 drives run_en to 0 on the clock edge that takes the second write.
- R3: Writing bits [15:0] = 0xBBBB and then bits [15:0] = 0x4444 to address 0 drives run_en to 1 on the clock edge that takes the second write.
- R4: Bits [31:16] of every key write are ignored by the sequence logic.
- R5: A key write whose low half is not the expected second word returns the tracker to idle and leaves run_en unchanged. This includes a repeat of the first word: 0xAAAA, 0xAAAA, 0x5555 does not halt.
- R6: Writes to other addresses between the two key words neither break nor complete a sequence.
- R7: A read of address 0 returns the full 32-bit value of the last key write. rd_data is valid in the cycle after rd_en.
- R8: Address 2+i is posted target i. An accepted write to it sets pend[i] on the next clock edge. Address 1 reads pend zero-extended, with bit i for target i.
- R9: pend[i] clears by itself once the watchdog domain acknowledges the write, and the written value then appears on slice i of wd_regs.
- R10: A write to target i while pend[i] is 1 is dropped. Neither the value read back from address 2+i nor the delivered value changes.
- R11: wd_count advances only while run_en, synchronized into the watchdog domain, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| run_en | output | 1 | Enable to the watchdog counter |
| pend | output | NPOST | Pending flag for each posted target |
| wclk | input | 1 | Watchdog-domain clock |
| wrst | input | 1 | Synchronous active-high reset, watchdog domain |
| wd_regs | output | NPOST*DW | Values delivered to the watchdog domain, target 0 in the low slice |
| wd_count | output | CW | Stub counter driven by the enable |

## Verification
Some rules are checked by assertions on every clock edge. The run flag may fall only after a completed halt pair and rise only after a completed resume pair. A cycle with no key write leaves the flag alone. An accepted posted write raises its pending bit, a write that hits a pending target leaves its holding register untouched, and the stub counter is frozen while its synchronized enable is low. Other behaviour only shows in the bench's scenarios: mismatched and repeated first words, key pairs split by other writes, don't-care upper halves, the full round trip through the handshake until the pending bit clears, and the delivered value surviving a dropped second write.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [15:0] KEY_HALT_1   = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_2   = 16'h5555;
  localparam logic [15:0] KEY_RESUME_1 = 16'hBBBB;
  localparam logic [15:0] KEY_RESUME_2 = 16'h4444;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HALT_ARMED,
    SQ_RESUME_ARMED
  } seq_state_t;
endpackage

// File: rtl/wdk_seq.sv
module wdk_seq
  import wdk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_we,
  input  logic [DW-1:0] key_wdata,
  output logic          run_o,
  output logic [DW-1:0] key_o
);
  seq_state_t    state;
  logic          run_q;
  logic [DW-1:0] key_q;
  logic [15:0]   low;

  assign low = key_wdata[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      run_q <= 1'b1;
      key_q <= '0;
    end else if (key_we) begin
      key_q <= key_wdata;
      case (state)
        SQ_IDLE: begin
          if (low == KEY_HALT_1)        state <= SQ_HALT_ARMED;
          else if (low == KEY_RESUME_1) state <= SQ_RESUME_ARMED;
          else                          state <= SQ_IDLE;
        end
        SQ_HALT_ARMED: begin
          if (low == KEY_HALT_2) run_q <= 1'b0;
          state <= SQ_IDLE;
        end
        SQ_RESUME_ARMED: begin
          if (low == KEY_RESUME_2) run_q <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign run_o = run_q;
  assign key_o = key_q;

  AST_HALT_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(key_we && key_wdata[15:0] == KEY_HALT_2 && state == SQ_HALT_ARMED)); // R2
  AST_RESUME_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(key_we && key_wdata[15:0] == KEY_RESUME_2 && state == SQ_RESUME_ARMED)); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !key_we |=> $stable(run_q)); // R6
endmodule

// File: rtl/wdk_post.sv
module wdk_post #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wclk,
  input  logic          wrst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          pend_o,
  output logic [DW-1:0] hold_o,
  output logic [DW-1:0] wd_val_o
);
  // bus side
  logic [DW-1:0] hold;
  logic          req_t, ack_s1, ack_s2, pend, accept;
  // watchdog side
  logic          req_s1, req_s2, req_s3;
  logic [DW-1:0] wd_val;

  assign pend   = req_t ^ ack_s2;
  assign accept = we && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      req_t  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (accept) begin
        hold  <= wdata;
        req_t <= ~req_t;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
      wd_val <= '0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      if (req_s2 != req_s3) wd_val <= hold;
    end
  end

  assign pend_o   = pend;
  assign hold_o   = hold;
  assign wd_val_o = wd_val;

  AST_ACCEPT_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    accept |=> pend); // R8
  AST_DROP_KEEPS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (we && pend) |=> $stable(hold)); // R10
endmodule

// File: rtl/wdk_stub.sv
module wdk_stub #(
  parameter int CW = 16
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          run_i,
  output logic [CW-1:0] count_o
);
  logic          en_s1, en_s2;
  logic [CW-1:0] count;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
      count <= '0;
    end else begin
      en_s1 <= run_i;
      en_s2 <= en_s1;
      if (en_s2) count <= count + 1'b1;
    end
  end

  assign count_o = count;

  AST_CNT_FROZEN: assert property (@(posedge wclk) disable iff (wrst)
    !en_s2 |=> $stable(count)); // R11
endmodule

// File: rtl/wdt_keyctl.sv
module wdt_keyctl #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NPOST = 2,
  parameter int CW    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic                run_en,
  output logic [NPOST-1:0]    pend,
  input  logic                wclk,
  input  logic                wrst,
  output logic [NPOST*DW-1:0] wd_regs,
  output logic [CW-1:0]       wd_count
);
  localparam logic [AW-1:0] ADDR_KEY  = AW'(0);
  localparam logic [AW-1:0] ADDR_PEND = AW'(1);
  localparam int            TGT_BASE  = 2;

  logic          key_we;
  logic [DW-1:0] key_val;
  logic          run_w;
  logic [DW-1:0] hold_a [NPOST];
  logic [NPOST-1:0] pend_w;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rd_q;

  assign key_we = wr_en && (addr == ADDR_KEY);

  wdk_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .key_we(key_we), .key_wdata(wr_data),
    .run_o(run_w), .key_o(key_val)
  );

  for (genvar i = 0; i < NPOST; i++) begin : g_post
    logic tgt_we;
    assign tgt_we = wr_en && (addr == AW'(TGT_BASE + i));
    wdk_post #(.DW(DW)) u_post (
      .clk(clk), .rst(rst), .wclk(wclk), .wrst(wrst),
      .we(tgt_we), .wdata(wr_data),
      .pend_o(pend_w[i]), .hold_o(hold_a[i]),
      .wd_val_o(wd_regs[i*DW +: DW])
    );
  end

  wdk_stub #(.CW(CW)) u_stub (
    .wclk(wclk), .wrst(wrst), .run_i(run_w), .count_o(wd_count)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_KEY)  rd_mux = key_val;
    if (addr == ADDR_PEND) rd_mux = DW'(pend_w);
    for (int j = 0; j < NPOST; j++)
      if (addr == AW'(TGT_BASE + j)) rd_mux = hold_a[j];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign run_en  = run_w;
  assign pend    = pend_w;

  AST_KEY_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_KEY && !wr_en) |=> (rd_data == $past(key_val))); // R7
endmodule

// File: tb/tb_wdt_keyctl.sv
module tb_wdt_keyctl;
  localparam int DW = 32, AW = 4, NPOST = 2, CW = 16;

  logic clk = 0, wclk = 0, rst = 1, wrst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic run_en;
  logic [NPOST-1:0] pend;
  logic [NPOST*DW-1:0] wd_regs;
  logic [CW-1:0] wd_count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always #10 wclk = ~wclk;

  wdt_keyctl #(.DW(DW), .AW(AW), .NPOST(NPOST), .CW(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .run_en(run_en), .pend(pend),
    .wclk(wclk), .wrst(wrst), .wd_regs(wd_regs), .wd_count(wd_count)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic        r;
  } vec_t;

  // address, data, expected run_en after the write
  localparam vec_t VECS [15] = '{
    '{4'd0, 32'h0000AAAA, 1'b1},
    '{4'd0, 32'h00005555, 1'b0},  // R2
    '{4'd0, 32'hFFFFBBBB, 1'b0},  // R4
    '{4'd0, 32'h12344444, 1'b1},  // R3 R4
    '{4'd0, 32'h0000AAAA, 1'b1},
    '{4'd0, 32'h00001234, 1'b1},  // R5
    '{4'd0, 32'h00005555, 1'b1},  // R5
    '{4'd0, 32'h0000AAAA, 1'b1},
    '{4'd0, 32'h0000AAAA, 1'b1},  // R5 repeat
    '{4'd0, 32'h00005555, 1'b1},  // R5
    '{4'd0, 32'hABCDAAAA, 1'b1},
    '{4'd2, 32'h00000011, 1'b1},  // R6 interleaved target write
    '{4'd0, 32'h00005555, 1'b0},  // R6
    '{4'd0, 32'h0000BBBB, 1'b0},
    '{4'd0, 32'h00004444, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wait_clear(input int idx);
    for (int k = 0; k < 200; k++) begin
      if (pend[idx] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [CW-1:0] c0;
    repeat (20) @(negedge clk);
    rst = 0; wrst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 run_en", 32'(run_en), 32'd1);
    chk("R1 pend", 32'(pend), 32'd0);
    chk("R1 wd_regs", wd_regs[31:0] | wd_regs[63:32], 32'd0);
    chk("R1 wd_count", 32'(wd_count), 32'd0);
    rd(4'd0, v);
    chk("R1 key read", v, 32'd0);

    for (int n = 0; n < 15; n++) begin
      wr(VECS[n].a, VECS[n].d);
      chk("R2/R3/R5/R6 run_en", 32'(run_en), 32'(VECS[n].r));
      if (VECS[n].a == 4'd0) begin
        rd(4'd0, v);
        chk("R7 key readback", v, VECS[n].d);
      end
    end

    // R9 target 0 delivered from the interleaved write
    wait_clear(0);
    chk("R9 pend0 cleared", 32'(pend[0]), 32'd0);
    chk("R9 wd_regs slice0", wd_regs[31:0], 32'h00000011);

    // R8 / R10 target 1
    wr(4'd3, 32'hCAFE0001);
    chk("R8 pend1 set", 32'(pend[1]), 32'd1);
    rd(4'd1, v);
    chk("R8 pend read", v & 32'h2, 32'h2);
    wr(4'd3, 32'hDEAD0002);
    rd(4'd3, v);
    chk("R10 hold kept", v, 32'hCAFE0001);
    wait_clear(1);
    chk("R9 pend1 cleared", 32'(pend[1]), 32'd0);
    chk("R10 delivered kept", wd_regs[63:32], 32'hCAFE0001);
    repeat (60) @(negedge clk);
    chk("R10 delivered after drop", wd_regs[63:32], 32'hCAFE0001);
    wr(4'd3, 32'h00000077);
    wait_clear(1);
    chk("R9 second delivery", wd_regs[63:32], 32'h00000077);

    // R11 counter follows enable
    c0 = wd_count;
    repeat (100) @(negedge clk);
    checks++;
    if (!(wd_count != c0)) begin
      fails++;
      $display("FAIL R11 running actual=%h expected=!%h", wd_count, c0);
    end
    wr(4'd0, 32'h0000AAAA);
    wr(4'd0, 32'h00005555);
    chk("R2 halt again", 32'(run_en), 32'd0);
    repeat (40) @(negedge clk);
    c0 = wd_count;
    repeat (100) @(negedge clk);
    chk("R11 frozen", 32'(wd_count), 32'(c0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule